// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows a decoded DRAM command stream and keeps, for each of four banks, whether a row is open and which row it is. It is meant to sit next to a memory controller's command issue stage as a protocol monitor and state source. Each command comes as a one-cycle strobe with a 3-bit command code, a bank number, a row address and the A10 bit. The tracker updates its per-bank state on that clock edge and raises a one-cycle violation pulse with a reason code when the command is not legal in the current state.

A PRECHARGE closes one bank or all banks, depending on A10. A READ or WRITE with A10 high closes its bank by itself after a set number of clocks. Until that happens the bank counts as open but closing. The tracker also enforces a minimum spacing, in clocks, between ACTIVATE commands to different banks. A command that is flagged never changes any bank state. All outputs come from registers or from the bank state registers, so each one changes on the clock edge that samples the command.

Top module: `bank_tracker`

## Requirements
- R1: While `rst` is high on a clock edge, every bank is closed after that edge, `all_idle` is 1 and `viol` is 0.
- R2: A legal ACTIVATE (code 1) to a closed bank sets `bank_open` for that bank after the sampling edge, and `bank_row` slice `[b*14 +: 14]` then holds the given row.
- R3: A READ (code 2) or WRITE (code 3) to a bank that is not open raises `viol` with reason 1 and changes no state.
- R4: A PRECHARGE (code 4) with A10 low closes only the addressed bank. With A10 high it closes all banks, and any pending auto-close is cancelled. A PRECHARGE to a closed bank is not a violation.
- R5: A legal READ with A10 high keeps the bank open for RD_AP_DLY edges after the command edge and closes it on the last of them. A WRITE with A10 high does the same with WR_AP_DLY. A READ or WRITE with A10 low leaves the bank open.
- R6: A READ or WRITE to a bank that is waiting for an auto-close raises `viol` with reason 5 and does not restart the countdown.
- R7: An ACTIVATE to a bank that is already open, including one that is closing, raises `viol` with reason 2 and leaves the stored row unchanged.
- R8: An ACTIVATE to a closed bank that differs from the bank of the last accepted ACTIVATE, issued fewer than RRD clocks after it, raises `viol` with reason 3 and the bank stays closed. After exactly RRD clocks it is legal. Rejected ACTIVATEs do not restart the spacing.
- R9: A REFRESH (code 5) or LOAD MODE (code 6) while any bank is open raises `viol` with reason 4. While all banks are closed it raises nothing. Neither command changes bank state.
- R10: `viol` is a one-cycle pulse registered on the edge that samples the offending command, and `viol_reason` is 0 whenever `viol` is 0. A cycle with `cmd_valid` low, a NOP (code 0) or the unused code 7 changes no state and raises no violation.
- R11: `all_idle` is 1 exactly when no bit of `bank_open` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 LOAD MODE |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | 14 | Row address (used on ACTIVATE) |
| cmd_a10 | input | 1 | All-bank select on PRECHARGE, auto-close on READ/WRITE |
| bank_open | output | 4 | Per-bank open flag |
| bank_row | output | 56 | Open row of each bank, 14 bits per bank, bank 0 lowest |
| all_idle | output | 1 | No bank open |
| viol | output | 1 | Protocol violation pulse |
| viol_reason | output | 3 | 1 access to closed bank, 2 activate open bank, 3 activate too soon, 4 refresh/mode with bank open, 5 access to closing bank |

## Verification
Directed sequences cover each rule in isolation. Back-to-back ACTIVATEs to two banks at gaps of one and two clocks separate a correct spacing check from an off-by-one. READs with and without A10, followed by probes in every cycle of the countdown, show whether the auto-close lands on the right edge and whether a late access is told apart from an access to a closed bank. PRECHARGE with A10 low against A10 high shows whether only the addressed bank closes or all of them. A long seeded random stream weighted toward ACTIVATE and access commands then mixes overlapping countdowns, repeated ACTIVATEs and REFRESH attempts. A model in the bench checks every cycle of that stream.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;
  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_RD  = 3'd2;
  localparam logic [2:0] OP_WR  = 3'd3;
  localparam logic [2:0] OP_PRE = 3'd4;
  localparam logic [2:0] OP_REF = 3'd5;
  localparam logic [2:0] OP_LMR = 3'd6;

  typedef enum logic [2:0] {
    WHY_NONE     = 3'd0,
    WHY_CLOSED   = 3'd1,
    WHY_REOPEN   = 3'd2,
    WHY_TOO_SOON = 3'd3,
    WHY_BUSY     = 3'd4,
    WHY_CLOSING  = 3'd5
  } why_e;

  typedef enum logic [1:0] {
    SL_IDLE    = 2'd0,
    SL_OPEN    = 2'd1,
    SL_CLOSING = 2'd2
  } slot_st_e;
endpackage

// File: rtl/bank_slot.sv
module bank_slot
  import bank_trk_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             close_i,
  input  logic             ap_i,
  input  logic [CNT_W-1:0] ap_dly_i,
  output logic             is_open_o,
  output logic             closing_o,
  output logic [ROW_W-1:0] row_o
);
  slot_st_e         st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SL_IDLE;
      cnt   <= '0;
      row_o <= '0;
    end else if (close_i) begin
      st <= SL_IDLE;
    end else if (open_i) begin
      st    <= SL_OPEN;
      row_o <= row_i;
    end else if (ap_i) begin
      st  <= SL_CLOSING;
      cnt <= ap_dly_i;
    end else if (st == SL_CLOSING) begin
      if (cnt == CNT_W'(1)) st <= SL_IDLE;
      else                  cnt <= cnt - CNT_W'(1);
    end
  end

  assign is_open_o = (st != SL_IDLE);
  assign closing_o = (st == SL_CLOSING);

  a_r2_open_latches_row: assert property (@(posedge clk) disable iff (rst)
    (!rst && open_i && !close_i) |=> (is_open_o && row_o == $past(row_i)));
  a_r4_close_wins: assert property (@(posedge clk) disable iff (rst)
    (!rst && close_i) |=> !is_open_o);
  a_r5_countdown_ends: assert property (@(posedge clk) disable iff (rst)
    (!rst && st == SL_CLOSING && cnt == CNT_W'(1) && !close_i && !open_i && !ap_i) |=> (st == SL_IDLE));
  a_r6_ap_only_when_open: assert property (@(posedge clk) disable iff (rst)
    ap_i |-> (st == SL_OPEN));
endmodule

// File: rtl/act_spacer.sv
module act_spacer #(
  parameter int RRD  = 2,
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic [BA_W-1:0] bank_i,
  output logic            too_soon_o
);
  localparam int GAP_W = $clog2(RRD + 1);

  logic [GAP_W-1:0] since;
  logic [BA_W-1:0]  last_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      since     <= GAP_W'(RRD);
      last_bank <= '0;
    end else if (take_i) begin
      since     <= GAP_W'(1);
      last_bank <= bank_i;
    end else if (since < GAP_W'(RRD)) begin
      since <= since + GAP_W'(1);
    end
  end

  assign too_soon_o = (since < GAP_W'(RRD)) && (bank_i != last_bank);

  a_r8_no_close_pair: assert property (@(posedge clk) disable iff (rst)
    (RRD > 1 && !rst && take_i) |=> !(take_i && bank_i != $past(bank_i)));
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_trk_pkg::*;
#(
  parameter int NBANKS    = 4,
  parameter int ROW_W     = 14,
  parameter int RRD       = 2,
  parameter int RD_AP_DLY = 2,
  parameter int WR_AP_DLY = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_code,
  input  logic [1:0]              cmd_bank,
  input  logic [13:0]             cmd_row,
  input  logic                    cmd_a10,
  output logic [3:0]              bank_open,
  output logic [55:0]             bank_row,
  output logic                    all_idle,
  output logic                    viol,
  output logic [2:0]              viol_reason
);
  localparam int BA_W  = $clog2(NBANKS);
  localparam int MAXD  = (RD_AP_DLY > WR_AP_DLY) ? RD_AP_DLY : WR_AP_DLY;
  localparam int CNT_W = $clog2(MAXD + 1);

  logic [NBANKS-1:0] open_v, closing_v, sel;
  logic [NBANKS-1:0] open_en, close_en, ap_en;
  logic              too_soon, act_take, is_rdwr, legal;
  logic              tgt_open, tgt_closing, any_open;
  logic [CNT_W-1:0]  ap_dly;
  why_e              why_n;

  assign sel         = NBANKS'(1) << cmd_bank;
  assign tgt_open    = open_v[cmd_bank];
  assign tgt_closing = closing_v[cmd_bank];
  assign any_open    = |open_v;
  assign is_rdwr     = (cmd_code == OP_RD) || (cmd_code == OP_WR);

  always_comb begin
    why_n = WHY_NONE;
    if (cmd_valid) begin
      case (cmd_code)
        OP_ACT: begin
          if (tgt_open)      why_n = WHY_REOPEN;
          else if (too_soon) why_n = WHY_TOO_SOON;
        end
        OP_RD, OP_WR: begin
          if (!tgt_open)        why_n = WHY_CLOSED;
          else if (tgt_closing) why_n = WHY_CLOSING;
        end
        OP_REF, OP_LMR: begin
          if (any_open) why_n = WHY_BUSY;
        end
        default: why_n = WHY_NONE;
      endcase
    end
  end

  assign legal    = (why_n == WHY_NONE);
  assign act_take = cmd_valid && (cmd_code == OP_ACT) && legal;
  assign ap_dly   = (cmd_code == OP_RD) ? CNT_W'(RD_AP_DLY) : CNT_W'(WR_AP_DLY);

  act_spacer #(.RRD(RRD), .BA_W(BA_W)) u_spacer (
    .clk        (clk),
    .rst        (rst),
    .take_i     (act_take),
    .bank_i     (cmd_bank),
    .too_soon_o (too_soon)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_slot
    assign open_en[b]  = act_take && sel[b];
    assign close_en[b] = cmd_valid && (cmd_code == OP_PRE) && (cmd_a10 || sel[b]);
    assign ap_en[b]    = cmd_valid && is_rdwr && cmd_a10 && legal && sel[b];

    bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .open_i    (open_en[b]),
      .row_i     (cmd_row),
      .close_i   (close_en[b]),
      .ap_i      (ap_en[b]),
      .ap_dly_i  (ap_dly),
      .is_open_o (open_v[b]),
      .closing_o (closing_v[b]),
      .row_o     (bank_row[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol        <= 1'b0;
      viol_reason <= WHY_NONE;
    end else begin
      viol        <= !legal;
      viol_reason <= why_n;
    end
  end

  assign bank_open = open_v;
  assign all_idle  = ~any_open;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (all_idle && !viol));
  a_r3_access_closed: assert property (@(posedge clk) disable iff (rst)
    (!rst && cmd_valid && is_rdwr && !bank_open[cmd_bank]) |=> (viol && viol_reason == 3'd1));
  a_r4_all_close: assert property (@(posedge clk) disable iff (rst)
    (!rst && cmd_valid && cmd_code == OP_PRE && cmd_a10) |=> all_idle);
  a_r9_busy_refresh: assert property (@(posedge clk) disable iff (rst)
    (!rst && cmd_valid && (cmd_code == OP_REF || cmd_code == OP_LMR) && !all_idle) |=> (viol && viol_reason == 3'd4));
  a_r10_reason_zero: assert property (@(posedge clk) disable iff (rst)
    !viol |-> (viol_reason == 3'd0));
  a_r10_reason_set: assert property (@(posedge clk) disable iff (rst)
    viol |-> (viol_reason != 3'd0));
  a_r7_row_kept: assert property (@(posedge clk) disable iff (rst)
    (!rst && cmd_valid && cmd_code == OP_ACT && bank_open[cmd_bank] && !bank_open[cmd_bank] == 1'b0) |=> $stable(bank_row));
endmodule

// File: tb/bank_tracker_test.sv
module bank_tracker_test;
  localparam int RRD = 2;
  localparam int RDD = 2;
  localparam int WRD = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic        cmd_a10;
  logic [3:0]  bank_open;
  logic [55:0] bank_row;
  logic        all_idle;
  logic        viol;
  logic [2:0]  viol_reason;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  bit       m_open [4];
  bit       m_pend [4];
  int       m_cnt  [4];
  bit [13:0] m_row [4];
  int       m_since;
  int       m_last;
  int       e_why;
  string    e_tag;

  bank_tracker #(.RRD(RRD), .RD_AP_DLY(RDD), .WR_AP_DLY(WRD)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_a10(cmd_a10),
    .bank_open(bank_open), .bank_row(bank_row), .all_idle(all_idle),
    .viol(viol), .viol_reason(viol_reason)
  );

  always #2 clk = ~clk;

  function automatic bit any_m_open();
    for (int b = 0; b < 4; b++) if (m_open[b]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 0; m_pend[b] = 0; m_cnt[b] = 0;
    end
    m_since = RRD; m_last = 0; e_why = 0; e_tag = "R1";
  endtask

  task automatic model_step(bit v, int code, int bk, bit [13:0] row, bit a10);
    int why = 0;
    bit anyo = any_m_open();
    e_tag = "R10";
    if (v) begin
      case (code)
        1: begin
          e_tag = "R2";
          if (m_open[bk]) begin why = 2; e_tag = "R7"; end
          else if (m_since < RRD && bk != m_last) begin why = 3; e_tag = "R8"; end
        end
        2, 3: begin
          e_tag = a10 ? "R5" : "R3";
          if (!m_open[bk]) begin why = 1; e_tag = "R3"; end
          else if (m_pend[bk]) begin why = 5; e_tag = "R6"; end
        end
        4: e_tag = "R4";
        5, 6: begin
          e_tag = "R9";
          if (anyo) why = 4;
        end
        default: e_tag = "R10";
      endcase
    end
    // countdowns
    for (int b = 0; b < 4; b++) begin
      if (m_pend[b]) begin
        if (m_cnt[b] == 1) begin m_pend[b] = 0; m_open[b] = 0; end
        else m_cnt[b]--;
      end
    end
    // spacing counter
    if (v && code == 1 && why == 0) begin m_since = 1; m_last = bk; end
    else if (m_since < RRD) m_since++;
    // command effects
    if (v && why == 0) begin
      case (code)
        1: begin m_open[bk] = 1; m_pend[bk] = 0; m_row[bk] = row; end
        2, 3: if (a10) begin m_pend[bk] = 1; m_cnt[bk] = (code == 2) ? RDD : WRD; end
        4: for (int b = 0; b < 4; b++)
             if (a10 || b == bk) begin m_open[b] = 0; m_pend[b] = 0; end
        default: ;
      endcase
    end
    e_why = why;
  endtask

  task automatic compare();
    bit [3:0] eo;
    bit row_ok = 1;
    for (int b = 0; b < 4; b++) begin
      eo[b] = m_open[b];
      if (m_open[b] && bank_row[b*14 +: 14] != m_row[b]) row_ok = 0;
    end
    n_chk++;
    if (bank_open !== eo || !row_ok) begin
      n_bad++;
      $display("FAIL %s: bank_open=%b rows=%h expected open=%b", e_tag, bank_open, bank_row, eo);
    end
    n_chk++;
    if (viol !== (e_why != 0) || viol_reason !== 3'(e_why)) begin
      n_bad++;
      $display("FAIL %s: viol=%b reason=%0d expected viol=%b reason=%0d", e_tag, viol, viol_reason, e_why != 0, e_why);
    end
    n_chk++;
    if (all_idle !== (eo == 4'b0)) begin
      n_bad++;
      $display("FAIL R11: all_idle=%b expected %b", all_idle, eo == 4'b0);
    end
  endtask

  task automatic step(bit v, int code, int bk, bit [13:0] row, bit a10);
    cmd_valid = v; cmd_code = 3'(code); cmd_bank = 2'(bk); cmd_row = row; cmd_a10 = a10;
    model_step(v, code, bk, row, a10);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 14'h0, 0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1; cmd_valid = 0; cmd_code = 0; cmd_bank = 0; cmd_row = 0; cmd_a10 = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare(); // R1 reset state
    rst = 0;

    // R2 open, R8 spacing
    step(1, 1, 0, 14'h0123, 0);
    step(1, 1, 1, 14'h0456, 0);      // R8 one clock later: too soon
    step(1, 1, 1, 14'h0456, 0);      // R8 exactly RRD: legal
    step(1, 1, 2, 14'h1abc, 0);      // R8 too soon again
    step(0, 0, 0, 0, 0);
    step(1, 1, 2, 14'h1abc, 0);      // legal
    step(1, 2, 3, 0, 0);             // R3 read closed bank
    step(1, 3, 3, 0, 1);             // R3 write closed bank
    step(1, 1, 0, 14'h3fff, 0);      // R7 reopen, row kept
    step(1, 5, 0, 0, 0);             // R9 refresh busy
    step(1, 6, 0, 0, 0);             // R9 load mode busy
    step(1, 7, 1, 0, 1);             // R10 unused code
    step(1, 4, 0, 0, 0);             // R4 close bank 0 only
    step(1, 4, 0, 0, 0);             // R4 closed bank, no violation
    step(1, 2, 1, 0, 0);             // read no auto-close
    step(1, 2, 1, 0, 1);             // R5 read auto-close
    step(1, 2, 1, 0, 0);             // R6 closing bank
    step(0, 0, 0, 0, 0);             // bank 1 closes here
    step(1, 2, 1, 0, 0);             // R3 closed now
    step(1, 3, 2, 0, 1);             // R5 write auto-close
    idle(2);
    step(1, 1, 2, 14'h0001, 0);      // R7 still closing
    idle(2);                          // closes on last
    step(1, 1, 3, 14'h0777, 0);
    idle(1);
    step(1, 1, 0, 14'h0555, 0);
    step(1, 3, 0, 0, 1);             // write auto-close on 0
    step(1, 4, 2, 0, 1);             // R4 close all, cancel pending
    step(1, 5, 0, 0, 0);             // R9 idle refresh ok
    step(1, 6, 0, 0, 0);             // R9 idle load mode ok
    idle(3);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      int code;
      if      (r < 30) code = 1;
      else if (r < 45) code = 2;
      else if (r < 60) code = 3;
      else if (r < 75) code = 4;
      else if (r < 82) code = 5;
      else if (r < 86) code = 6;
      else if (r < 89) code = 7;
      else             code = 0;
      step($urandom_range(0, 9) != 0, code, $urandom_range(0, 3),
           14'($urandom), $urandom_range(0, 3) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule